// File: doc/BRIEF.md
# Circular Result Buffer Writer

This block sits between a converter that emits signed 16-bit results and a memory that stores them. Each result that arrives while the transfer engine is switched on is written to memory one cycle later, at the next slot of a ring buffer. Software or a controller supplies the ring's start address and its length in 16-bit entries. The block walks that ring in order and returns to the start after the final slot. It emits a one-cycle event when the write lands on the last slot of the first half of the ring, and another when it lands on the final slot. A consumer can therefore drain one half while the other half fills.

The converter keeps producing results when the engine is switched off. Each result that arrives while the engine is off is discarded, and a one-cycle overflow event reports the loss. When the engine is switched back on, the ring pointer goes back to the start address. The first stored result after an enable therefore always sits at the base.

Top module: `circ_result_writer`

## Requirements
- R1: During and right after a synchronous active-low reset, mem_we, mem_addr, mem_wdata, evt_half, evt_full and evt_ovf are all zero.
- R2: A result is accepted when res_valid and dma_en are both 1 on a clock edge. One cycle later, mem_we is 1 for exactly that cycle and mem_wdata holds the result bits unchanged, including the extreme signed values 16'h8000 and 16'h7FFF.
- R3: Accepted results go to consecutive entry addresses. The k-th result since the ring start is written at mem_addr = buf_base + k, with addresses counted in 16-bit entries.
- R4: A cycle where dma_en is 1 and dma_en was 0 on the previous edge (or reset was active) restarts the ring. A result accepted in that same cycle is written at buf_base, whatever position the ring held before.
- R5: evt_half is 1 in exactly the cycle whose write goes to index buf_len/2 - 1.
- R6: evt_full is 1 in exactly the cycle whose write goes to index buf_len - 1. The next accepted result is written at buf_base.
- R7: When res_valid is 1 and dma_en is 0 on an edge, the next cycle has mem_we = 0 and evt_ovf = 1, and the ring position does not advance.
- R8: A cycle after an edge with res_valid = 0 has mem_we, evt_half, evt_full and evt_ovf all 0. mem_we and evt_ovf are never 1 together.
- R9: With the minimum length buf_len = 2, evt_half accompanies the write at index 0 and evt_full the write at index 1, and the two repeat on every lap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| res_valid | input | 1 | One-cycle strobe: a conversion result is ready |
| res_data | input | 16 | Signed conversion result |
| dma_en | input | 1 | Transfer engine on |
| buf_base | input | ADDR_W | Ring start address, in entries |
| buf_len | input | LEN_W | Ring length in entries; even and at least 2 |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address, in entries |
| mem_wdata | output | 16 | Memory write data |
| evt_half | output | 1 | Write landed on the last slot of the first half |
| evt_full | output | 1 | Write landed on the final slot |
| evt_ovf | output | 1 | A result was dropped because the engine was off |

## Verification
Two things can fall in the same cycle: the ring restart caused by turning the engine on, and the acceptance of a result. The bench fills part of the ring, switches the engine off and presents a result so that it is dropped. It then switches the engine on in the very cycle a new result is valid. The test passes only if that write lands at buf_base and not at the old position, and if the following write moves on to base + 1 and raises the half event. The wrap is a second coincidence: the full event and the return of the pointer to the base happen together. The bench checks it by expecting the write right after evt_full at offset zero.

// File: rtl/crw_pkg.sv
// Shared types for the circular result writer.
// Assumes results are two's-complement words of SAMPLE_W bits.
package crw_pkg;
    localparam int SAMPLE_W = 16;
    typedef logic signed [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/crw_index_ctrl.sv
// Ring index controller: holds the position of the next slot, restarts it
// on an enable edge, and wraps it after the final slot.
// Assumes len is even, at least 2, and stable while results are accepted.
module crw_index_ctrl #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             restart,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] cur_idx,
    output logic             at_half,
    output logic             at_last
);
    logic [LEN_W-1:0] idx_q;
    logic [LEN_W-1:0] half_idx;
    logic [LEN_W-1:0] last_idx;

    // Marker positions derived from the programmed length.
    always_comb begin
        half_idx = (len >> 1) - LEN_W'(1);
        last_idx = len - LEN_W'(1);
    end

    // Slot used this cycle: a restart overrides the stored position.
    always_comb begin
        cur_idx = restart ? '0 : idx_q;
        at_half = (cur_idx == half_idx);
        at_last = (cur_idx == last_idx);
    end

    // Advance on acceptance, wrap after the last slot, clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (accept) begin
            idx_q <= at_last ? '0 : cur_idx + LEN_W'(1);
        end else if (restart) begin
            idx_q <= '0;
        end
    end

    // R6: after the final slot the next position is the base.
    a_r6_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && at_last) |=> (idx_q == '0));

    // R7: with no acceptance and no restart the position holds.
    a_r7_hold_position: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !restart) |=> $stable(idx_q));

    // R3: an accepted slot lies inside the ring.
    a_r3_index_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (cur_idx < len));
endmodule

// File: rtl/crw_write_stage.sv
// Output register stage: turns an accepted or dropped result into one
// registered memory write or overflow event, with marker strobes.
// Assumes accept and drop are never both set.
module crw_write_stage #(
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic                  drop,
    input  logic [ADDR_W-1:0]     addr_in,
    input  crw_pkg::sample_t      data_in,
    input  logic                  half_hit,
    input  logic                  last_hit,
    output logic                  we,
    output logic [ADDR_W-1:0]     addr,
    output crw_pkg::sample_t      wdata,
    output logic                  half_evt,
    output logic                  full_evt,
    output logic                  ovf_evt
);
    // One-cycle strobes for the write and its events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we       <= 1'b0;
            half_evt <= 1'b0;
            full_evt <= 1'b0;
            ovf_evt  <= 1'b0;
        end else begin
            we       <= accept;
            half_evt <= accept && half_hit;
            full_evt <= accept && last_hit;
            ovf_evt  <= drop;
        end
    end

    // Address and data load only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            wdata <= '0;
        end else if (accept) begin
            addr  <= addr_in;
            wdata <= data_in;
        end
    end

    // R5: marker strobes only accompany a write.
    a_r5_half_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        half_evt |-> we);
    a_r6_full_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        full_evt |-> we);
    // R8: a write and an overflow never share a cycle.
    a_r8_write_xor_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we, ovf_evt}));
endmodule

// File: rtl/circ_result_writer.sv
// Circular result writer: stores accepted conversion results into a ring
// of buf_len entries starting at buf_base, flags half and full points and
// reports results dropped while the engine is off.
// Assumes buf_len is even, at least 2, and buf_base and buf_len are stable
// while dma_en is 1; ADDR_W is at least LEN_W.
module circ_result_writer #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  res_valid,
    input  logic [15:0]           res_data,
    input  logic                  dma_en,
    input  logic [ADDR_W-1:0]     buf_base,
    input  logic [LEN_W-1:0]      buf_len,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [15:0]           mem_wdata,
    output logic                  evt_half,
    output logic                  evt_full,
    output logic                  evt_ovf
);
    import crw_pkg::*;

    logic             en_q;
    logic             restart;
    logic             accept;
    logic             drop;
    logic [LEN_W-1:0] cur_idx;
    logic             at_half;
    logic             at_last;
    logic [ADDR_W-1:0] slot_addr;
    sample_t          wdata_s;

    // Remember the enable level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= dma_en;
    end

    // Classify this cycle's result and detect a ring restart.
    always_comb begin
        restart   = dma_en && !en_q;
        accept    = res_valid && dma_en;
        drop      = res_valid && !dma_en;
        slot_addr = buf_base + ADDR_W'(cur_idx);
    end

    crw_index_ctrl #(.LEN_W(LEN_W)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .restart (restart),
        .len     (buf_len),
        .cur_idx (cur_idx),
        .at_half (at_half),
        .at_last (at_last)
    );

    crw_write_stage #(.ADDR_W(ADDR_W)) u_write (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .drop     (drop),
        .addr_in  (slot_addr),
        .data_in  (sample_t'(res_data)),
        .half_hit (at_half),
        .last_hit (at_last),
        .we       (mem_we),
        .addr     (mem_addr),
        .wdata    (wdata_s),
        .half_evt (evt_half),
        .full_evt (evt_full),
        .ovf_evt  (evt_ovf)
    );

    // Present the stored sample as plain bits.
    always_comb mem_wdata = 16'(wdata_s);

    // R2: an accepted result becomes one write of the same bits.
    a_r2_accept_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && dma_en) |=> (mem_we && mem_wdata == $past(res_data)));
    // R7: a result with the engine off is dropped with an overflow event.
    a_r7_drop_overflows: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !dma_en) |=> (evt_ovf && !mem_we));
    // R8: no result, no write and no events.
    a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> (!mem_we && !evt_ovf && !evt_half && !evt_full));
    // R4: a result on the enable edge lands at the base.
    a_r4_restart_at_base: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && dma_en && !en_q) |=> (mem_addr == $past(buf_base)));
endmodule

// File: tb/circ_result_writer_test.sv
module circ_result_writer_test;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 12;
    localparam logic [15:0] BASE = 16'h0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic dma_en = 1'b0;
    logic [ADDR_W-1:0] buf_base = BASE;
    logic [LEN_W-1:0] buf_len = 12'd4;
    logic mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic evt_half, evt_full, evt_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    circ_result_writer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .dma_en(dma_en), .buf_base(buf_base), .buf_len(buf_len),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .evt_half(evt_half), .evt_full(evt_full), .evt_ovf(evt_ovf)
    );

    typedef struct packed {
        logic        v;
        logic        en;
        logic [15:0] d;
        logic        we;
        logic [3:0]  off;
        logic        h;
        logic        f;
        logic        o;
    } vec_t;

    // Ring length 4, base 0x100.
    localparam vec_t VEC [12] = '{
        '{1'b1, 1'b0, 16'h1111, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1}, // R7 drop
        '{1'b0, 1'b1, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0}, // R8 enable, idle
        '{1'b1, 1'b1, 16'h8000, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0}, // R2 R3 slot 0
        '{1'b1, 1'b1, 16'h7FFF, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0}, // R5 slot 1 half
        '{1'b0, 1'b1, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0}, // R8 gap
        '{1'b1, 1'b1, 16'hFFFF, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0}, // R3 slot 2
        '{1'b1, 1'b1, 16'h0001, 1'b1, 4'd3, 1'b0, 1'b1, 1'b0}, // R6 slot 3 full
        '{1'b1, 1'b1, 16'h1234, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0}, // R6 wrap
        '{1'b1, 1'b0, 16'hAAAA, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1}, // R7 drop
        '{1'b0, 1'b0, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0}, // R8 idle
        '{1'b1, 1'b1, 16'h5555, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0}, // R4 restart+accept
        '{1'b1, 1'b1, 16'h0002, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0}  // R4 then half
    };

    task automatic compare(string tag, logic we, logic [15:0] addr, logic [15:0] dat,
                           logic h, logic f, logic o);
        logic ok;
        checks++;
        ok = (mem_we === we) && (evt_half === h) && (evt_full === f) && (evt_ovf === o);
        if (we) ok = ok && (mem_addr === addr) && (mem_wdata === dat);
        if (!ok) begin
            errors++;
            $display("FAIL %s: got we=%b addr=%h data=%h h=%b f=%b o=%b, expected we=%b addr=%h data=%h h=%b f=%b o=%b",
                     tag, mem_we, mem_addr, mem_wdata, evt_half, evt_full, evt_ovf,
                     we, addr, dat, h, f, o);
        end
    endtask

    // Apply inputs on the falling edge, let one rising edge pass, then look.
    task automatic step(logic v, logic en, logic [15:0] d);
        @(negedge clk);
        res_valid = v; dma_en = en; res_data = d;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; res_valid = 1'b0; dma_en = 1'b0;
        @(posedge clk); @(posedge clk);
        #2;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: outputs zero while in reset.
        do_reset();
        compare("R1 in reset", 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
        checks++;
        if (mem_addr !== '0 || mem_wdata !== '0) begin
            errors++;
            $display("FAIL R1: got addr=%h data=%h, expected 0 0", mem_addr, mem_wdata);
        end
        @(negedge clk); rst_n = 1'b1;

        // Vector table: ring of 4.
        for (int i = 0; i < 12; i++) begin
            step(VEC[i].v, VEC[i].en, VEC[i].d);
            compare($sformatf("vector %0d", i), VEC[i].we, BASE + 16'(VEC[i].off),
                    VEC[i].d, VEC[i].h, VEC[i].f, VEC[i].o);
        end

        // R2: write strobe lasts one cycle only.
        step(1'b0, 1'b1, 16'h0);
        compare("R2 single-cycle write", 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);

        // R1: reset in mid-run clears outputs.
        step(1'b1, 1'b1, 16'h0BAD);
        do_reset();
        compare("R1 mid-run reset", 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);

        // R9: minimum ring length 2, different base.
        buf_len = 12'd2; buf_base = 16'h0040;
        @(negedge clk); rst_n = 1'b1;
        for (int lap = 0; lap < 2; lap++) begin
            step(1'b1, 1'b1, 16'h00A0 + 16'(lap));
            compare("R9 slot 0 half", 1'b1, 16'h0040, 16'h00A0 + 16'(lap), 1'b1, 1'b0, 1'b0);
            step(1'b1, 1'b1, 16'h00B0 + 16'(lap));
            compare("R9 slot 1 full", 1'b1, 16'h0041, 16'h00B0 + 16'(lap), 1'b0, 1'b1, 1'b0);
        end

        // R7: position holds across dropped results; R4 re-enable restarts.
        step(1'b1, 1'b1, 16'h00C0);
        compare("R3 slot 0 again", 1'b1, 16'h0040, 16'h00C0, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 16'h00C1);
        compare("R7 drop while off", 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 16'h0);
        step(1'b1, 1'b1, 16'h00C2);
        compare("R4 restart without result", 1'b1, 16'h0040, 16'h00C2, 1'b1, 1'b0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule